// File: doc/BRIEF.md
# Serial Line Register Window

This block is the host-side register window of an eight-line asynchronous serial controller. The host sees two 16-bit words. The first is a control/status word. It holds the transmit and receive interrupt flags and their enables, a memory-error flag, the number of the line that last reported, a master-clear bit and a 5-bit selector. The second is a data word. Its meaning depends on the selector, which picks one line and one of four per-line registers. As a result, every line's state is reached through a single shared pair of byte lanes. Neither byte has a fixed meaning.

For each line the block holds a line-control byte, a transmit modem-status byte and two 16-bit transfer registers (start address and character count). Writing the character byte sends one character to the selected line's transmit FIFO. Writing the flush bit sends a one-cycle flush strobe to that FIFO. Hardware event inputs set the transmit flag and record the reporting line. The receive flag follows a data-ready level. The two interrupt requests are each a flag ANDed with its enable.

Top module: `sio_regwin`

## Requirements
- R1: After synchronous reset:
  - the control word reads 0x0000;
  - all line-control and modem outputs are 0;
  - no push or flush strobe is active.
- R2: The control word has this layout:
  - bit 14 is the transmit enable;
  - bit 6 is the receive enable;
  - bits 4:0 are the selector.
  
  All three fields read back as written. Bits 10:8 (line number) and bit 7 (receive flag, equal to `rx_ready_i`) ignore host writes.
- R3: A `tx_event_i` pulse does three things:
  - sets bit 15 (transmit flag);
  - loads bits 10:8 with `tx_line_i`;
  - sets bit 13 if `tx_nxm_i` is high.
  
  A host write to the high byte clears bit 15 where it writes 0, and clears bit 13 where it writes 0. An event in the same cycle as such a write wins.
- R4: `tx_irq_o` equals bit 15 AND bit 14. `rx_irq_o` equals bit 7 AND bit 6.
- R5: Selector bits 4:3 choose the register: 00 character, 01 line control, 10 transfer address, 11 transfer count. Selector bits 2:0 choose the line.
- R6: With the character register selected, a low-byte data write has this effect one cycle later:
  - `silo_push_o` pulses for one cycle, one-hot on the selected line;
  - `silo_data_o` holds the written byte.
  
  A high-byte-only write pushes nothing.
- R7: With the character register selected, a read returns:
  - the low byte = that line's FIFO fill count;
  - the high byte = that line's receive modem inputs in bits 7:2, with bits 1:0 = 0.
- R8: With line control selected, the low byte is the line-control register. It stores bits 5, 3, 2, 1 and 0, which drive `line_ctrl_o`. Writing 1 to bit 4 pulses `silo_flush_o` on that line one cycle later. Bit 4 always reads 0.
- R9: With line control selected, the high byte is the modem-status register. Bits 7 and 5:0 are stored, and bit 6 reads 0. `modem_out_o` for the line is bits 4:0.
- R10: The transfer address and transfer count are separate 16-bit registers for each line. They are visible on `dma_addr_o` and `dma_cnt_o`.
- R11: Writing 1 to control bit 5 works as follows:
  - bit 5 reads 1 for exactly one cycle;
  - then all line-control registers, all modem-status registers, bit 14 and bit 6 are cleared;
  - transfer registers are unchanged.
- R12: `byte_en_i` bit 0 gates the low byte and bit 1 gates the high byte. A byte that is not enabled is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe |
| data_sel_i | input | 1 | 0 selects the control word, 1 the data word |
| byte_en_i | input | 2 | Byte lane enables |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Read data for the word chosen by data_sel_i |
| tx_event_i | input | 1 | Transmit completion event |
| tx_line_i | input | 3 | Line reporting the event |
| tx_nxm_i | input | 1 | Memory error accompanying the event |
| rx_ready_i | input | 1 | Receive data available |
| silo_count_i | input | NUM_LINES*CNT_W | Per-line transmit FIFO fill counts |
| rx_modem_i | input | NUM_LINES*6 | Per-line receive modem inputs (status bits 7:2) |
| silo_push_o | output | NUM_LINES | Per-line character push strobe |
| silo_flush_o | output | NUM_LINES | Per-line FIFO flush strobe |
| silo_data_o | output | 8 | Pushed character |
| line_ctrl_o | output | NUM_LINES*6 | Per-line line-control image |
| modem_out_o | output | NUM_LINES*5 | Per-line modem output signals |
| dma_addr_o | output | NUM_LINES*16 | Per-line transfer address |
| dma_cnt_o | output | NUM_LINES*16 | Per-line transfer count |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is a collision on the same edge. Two collisions are of interest:
- a host write clearing the transmit flag while a new event sets it;
- a master clear that is pending while other registers are being written.

The stimulus drives the event and the write inside the same clock cycle. It also checks that the clear bit is visible for exactly one read cycle. A seeded random sequence of selector writes and partial-byte data writes across all lines and registers then compares every readback against a bench model. This shows that the aliased byte lanes never update the wrong line or register.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int LINE_W = 3;
    localparam int IAD_W  = 5;

    typedef enum logic [1:0] {
        RS_CHAR = 2'b00,
        RS_LCTL = 2'b01,
        RS_XADR = 2'b10,
        RS_XCNT = 2'b11
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           rsel;
        logic [LINE_W-1:0]  line;
    } iad_t;

    typedef struct packed {
        logic               ti;
        logic               tie;
        logic               nxm;
        logic [1:0]         rsvd;
        logic [LINE_W-1:0]  line;
        logic               ri;
        logic               rie;
        logic               clr;
        iad_t               iad;
    } csr_t;

    typedef struct packed {
        logic mie;
        logic flush;
        logic rbrk;
        logic rxen;
        logic autox;
        logic txen;
    } lctl_t;

    localparam logic [5:0] LCTL_KEEP = 6'h2F;
    localparam logic [7:0] MSTAT_KEEP = 8'hBF;

    function automatic lctl_t lctl_from_bits(input logic [5:0] b);
        return lctl_t'(b & LCTL_KEEP);
    endfunction

    function automatic logic [7:0] mstat_from_byte(input logic [7:0] b);
        return b & MSTAT_KEEP;
    endfunction

endpackage

// File: rtl/sio_csr.sv
module sio_csr
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rie_d,
    input  logic              clr_d,
    input  iad_t              iad_d,
    input  logic              tie_d,
    input  logic              ti_d,
    input  logic              nxm_d,
    input  logic              tx_event,
    input  logic [LINE_W-1:0] tx_line,
    input  logic              tx_nxm,
    input  logic              rx_ready,
    output csr_t              csr_o,
    output logic              clr_o,
    output iad_t              iad_o,
    output logic              tx_irq,
    output logic              rx_irq
);

    logic              ti_q, tie_q, nxm_q, rie_q, clr_q;
    logic [LINE_W-1:0] line_q;
    iad_t              iad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ti_q   <= 1'b0;
            tie_q  <= 1'b0;
            nxm_q  <= 1'b0;
            rie_q  <= 1'b0;
            clr_q  <= 1'b0;
            line_q <= '0;
            iad_q  <= '0;
        end else begin
            if (clr_q) begin
                tie_q <= 1'b0;
                rie_q <= 1'b0;
                clr_q <= 1'b0;
            end else begin
                if (wr_lo) begin
                    rie_q <= rie_d;
                    clr_q <= clr_d;
                end
                if (wr_hi) tie_q <= tie_d;
            end
            if (wr_lo) iad_q <= iad_d;
            if (tx_event) begin
                ti_q   <= 1'b1;
                line_q <= tx_line;
                if (tx_nxm) nxm_q <= 1'b1;
            end else if (wr_hi) begin
                if (!ti_d)  ti_q  <= 1'b0;
                if (!nxm_d) nxm_q <= 1'b0;
            end
        end
    end

    always_comb begin
        csr_o      = '0;
        csr_o.ti   = ti_q;
        csr_o.tie  = tie_q;
        csr_o.nxm  = nxm_q;
        csr_o.line = line_q;
        csr_o.ri   = rx_ready;
        csr_o.rie  = rie_q;
        csr_o.clr  = clr_q;
        csr_o.iad  = iad_q;
    end

    assign clr_o  = clr_q;
    assign iad_o  = iad_q;
    assign tx_irq = ti_q & tie_q;
    assign rx_irq = rx_ready & rie_q;

endmodule

// File: rtl/sio_line_regs.sv
module sio_line_regs
    import sio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        hit,
    input  reg_sel_e    rsel,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [15:0] wdata,
    output lctl_t       lctl_o,
    output logic [7:0]  mstat_o,
    output logic [15:0] xadr_o,
    output logic [15:0] xcnt_o,
    output logic        push_o,
    output logic        flush_o
);

    lctl_t       lctl_q;
    logic [7:0]  mstat_q;
    logic [15:0] xadr_q, xcnt_q;
    logic        push_q, flush_q;

    logic sel_char, sel_lctl, sel_xadr, sel_xcnt;
    assign sel_char = hit && (rsel == RS_CHAR);
    assign sel_lctl = hit && (rsel == RS_LCTL);
    assign sel_xadr = hit && (rsel == RS_XADR);
    assign sel_xcnt = hit && (rsel == RS_XCNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lctl_q  <= '0;
            mstat_q <= '0;
            xadr_q  <= '0;
            xcnt_q  <= '0;
            push_q  <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            push_q  <= sel_char && wr_lo;
            flush_q <= sel_lctl && wr_lo && wdata[4];
            if (clr) begin
                lctl_q  <= '0;
                mstat_q <= '0;
            end else begin
                if (sel_lctl && wr_lo) lctl_q  <= lctl_from_bits(wdata[5:0]);
                if (sel_lctl && wr_hi) mstat_q <= mstat_from_byte(wdata[15:8]);
            end
            if (sel_xadr && wr_lo) xadr_q[7:0]  <= wdata[7:0];
            if (sel_xadr && wr_hi) xadr_q[15:8] <= wdata[15:8];
            if (sel_xcnt && wr_lo) xcnt_q[7:0]  <= wdata[7:0];
            if (sel_xcnt && wr_hi) xcnt_q[15:8] <= wdata[15:8];
        end
    end

    assign lctl_o  = lctl_q;
    assign mstat_o = mstat_q;
    assign xadr_o  = xadr_q;
    assign xcnt_o  = xcnt_q;
    assign push_o  = push_q;
    assign flush_o = flush_q;

endmodule

// File: rtl/sio_read_mux.sv
module sio_read_mux
    import sio_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int CNT_W     = 6
) (
    input  csr_t                      csr,
    input  logic                      data_sel,
    input  iad_t                      iad,
    input  logic [NUM_LINES*6-1:0]    lctl_all,
    input  logic [NUM_LINES*8-1:0]    mstat_all,
    input  logic [NUM_LINES*16-1:0]   xadr_all,
    input  logic [NUM_LINES*16-1:0]   xcnt_all,
    input  logic [NUM_LINES*CNT_W-1:0] cnt_all,
    input  logic [NUM_LINES*6-1:0]    rms_all,
    output logic [15:0]               rdata
);

    logic [15:0] word;

    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (iad.line == LINE_W'(i)) begin
                unique case (iad.rsel)
                    RS_CHAR: word = {rms_all[i*6 +: 6], 2'b00,
                                     8'(cnt_all[i*CNT_W +: CNT_W])};
                    RS_LCTL: word = {mstat_all[i*8 +: 8], 2'b00,
                                     lctl_all[i*6 +: 6]};
                    RS_XADR: word = xadr_all[i*16 +: 16];
                    RS_XCNT: word = xcnt_all[i*16 +: 16];
                    default: word = '0;
                endcase
            end
        end
    end

    assign rdata = data_sel ? word : 16'(csr);

endmodule

// File: rtl/sio_regwin.sv
module sio_regwin
    import sio_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter int SILO_DEPTH = 32,
    localparam int CNT_W     = $clog2(SILO_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic                        data_sel_i,
    input  logic [1:0]                  byte_en_i,
    input  logic [15:0]                 wdata_i,
    output logic [15:0]                 rdata_o,
    input  logic                        tx_event_i,
    input  logic [LINE_W-1:0]           tx_line_i,
    input  logic                        tx_nxm_i,
    input  logic                        rx_ready_i,
    input  logic [NUM_LINES*CNT_W-1:0]  silo_count_i,
    input  logic [NUM_LINES*6-1:0]      rx_modem_i,
    output logic [NUM_LINES-1:0]        silo_push_o,
    output logic [NUM_LINES-1:0]        silo_flush_o,
    output logic [7:0]                  silo_data_o,
    output logic [NUM_LINES*6-1:0]      line_ctrl_o,
    output logic [NUM_LINES*5-1:0]      modem_out_o,
    output logic [NUM_LINES*16-1:0]     dma_addr_o,
    output logic [NUM_LINES*16-1:0]     dma_cnt_o,
    output logic                        tx_irq_o,
    output logic                        rx_irq_o
);

    logic wr_csr_lo, wr_csr_hi, wr_dat_lo, wr_dat_hi;
    assign wr_csr_lo = wr_en_i && !data_sel_i && byte_en_i[0];
    assign wr_csr_hi = wr_en_i && !data_sel_i && byte_en_i[1];
    assign wr_dat_lo = wr_en_i &&  data_sel_i && byte_en_i[0];
    assign wr_dat_hi = wr_en_i &&  data_sel_i && byte_en_i[1];

    csr_t csr;
    iad_t iad;
    logic csr_clr;

    sio_csr u_csr (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (wr_csr_lo),
        .wr_hi    (wr_csr_hi),
        .rie_d    (wdata_i[6]),
        .clr_d    (wdata_i[5]),
        .iad_d    (iad_t'(wdata_i[4:0])),
        .tie_d    (wdata_i[14]),
        .ti_d     (wdata_i[15]),
        .nxm_d    (wdata_i[13]),
        .tx_event (tx_event_i),
        .tx_line  (tx_line_i),
        .tx_nxm   (tx_nxm_i),
        .rx_ready (rx_ready_i),
        .csr_o    (csr),
        .clr_o    (csr_clr),
        .iad_o    (iad),
        .tx_irq   (tx_irq_o),
        .rx_irq   (rx_irq_o)
    );

    logic [NUM_LINES*8-1:0] mstat_all;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        lctl_t      lctl;
        logic [7:0] mstat;

        sio_line_regs u_line (
            .clk     (clk),
            .rst     (rst),
            .clr     (csr_clr),
            .hit     (iad.line == LINE_W'(g)),
            .rsel    (iad.rsel),
            .wr_lo   (wr_dat_lo),
            .wr_hi   (wr_dat_hi),
            .wdata   (wdata_i),
            .lctl_o  (lctl),
            .mstat_o (mstat),
            .xadr_o  (dma_addr_o[g*16 +: 16]),
            .xcnt_o  (dma_cnt_o[g*16 +: 16]),
            .push_o  (silo_push_o[g]),
            .flush_o (silo_flush_o[g])
        );

        assign line_ctrl_o[g*6 +: 6] = 6'(lctl);
        assign mstat_all[g*8 +: 8]   = mstat;
        assign modem_out_o[g*5 +: 5] = mstat[4:0];
    end

    logic [7:0] char_q;
    always_ff @(posedge clk) begin
        if (rst)
            char_q <= '0;
        else if (wr_dat_lo && iad.rsel == RS_CHAR)
            char_q <= wdata_i[7:0];
    end
    assign silo_data_o = char_q;

    sio_read_mux #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W)
    ) u_rmux (
        .csr       (csr),
        .data_sel  (data_sel_i),
        .iad       (iad),
        .lctl_all  (line_ctrl_o),
        .mstat_all (mstat_all),
        .xadr_all  (dma_addr_o),
        .xcnt_all  (dma_cnt_o),
        .cnt_all   (silo_count_i),
        .rms_all   (rx_modem_i),
        .rdata     (rdata_o)
    );

endmodule

// File: rtl/sio_regwin_chk.sv
module sio_regwin_chk #(
    parameter int NUM_LINES = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic                   data_sel,
    input logic                   be_lo,
    input logic [4:0]             iad,
    input logic                   clr,
    input logic [NUM_LINES-1:0]   push,
    input logic [NUM_LINES-1:0]   flush,
    input logic [NUM_LINES*6-1:0] lctl,
    input logic [NUM_LINES*5-1:0] mout,
    input logic                   rx_ready,
    input logic                   rx_irq
);

    assert_push_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push));

    assert_flush_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flush));

    assert_push_to_line_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && data_sel && be_lo && iad[4:3] == 2'b00)
        |=> push == (NUM_LINES'(1) << $past(iad[2:0])));

    assert_clear_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> !clr);

    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lctl == '0 && mout == '0));

    assert_rx_irq_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_ready);

endmodule

bind sio_regwin sio_regwin_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en_i),
    .data_sel (data_sel_i),
    .be_lo    (byte_en_i[0]),
    .iad      (5'(iad)),
    .clr      (csr_clr),
    .push     (silo_push_o),
    .flush    (silo_flush_o),
    .lctl     (line_ctrl_o),
    .mout     (modem_out_o),
    .rx_ready (rx_ready_i),
    .rx_irq   (rx_irq_o)
);

// File: tb/test_sio_regwin.sv
module test_sio_regwin;

    localparam int NL = 8;
    localparam int CW = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              data_sel = 1'b0;
    logic [1:0]        byte_en = 2'b00;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              tx_event = 1'b0;
    logic [2:0]        tx_line = '0;
    logic              tx_nxm = 1'b0;
    logic              rx_ready = 1'b0;
    logic [NL*CW-1:0]  silo_count;
    logic [NL*6-1:0]   rx_modem;
    logic [NL-1:0]     silo_push, silo_flush;
    logic [7:0]        silo_data;
    logic [NL*6-1:0]   line_ctrl;
    logic [NL*5-1:0]   modem_out;
    logic [NL*16-1:0]  dma_addr, dma_cnt;
    logic              tx_irq, rx_irq;

    always #2 clk = ~clk;

    sio_regwin i_sio_regwin (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .data_sel_i(data_sel),
        .byte_en_i(byte_en), .wdata_i(wdata), .rdata_o(rdata),
        .tx_event_i(tx_event), .tx_line_i(tx_line), .tx_nxm_i(tx_nxm),
        .rx_ready_i(rx_ready), .silo_count_i(silo_count), .rx_modem_i(rx_modem),
        .silo_push_o(silo_push), .silo_flush_o(silo_flush), .silo_data_o(silo_data),
        .line_ctrl_o(line_ctrl), .modem_out_o(modem_out), .dma_addr_o(dma_addr),
        .dma_cnt_o(dma_cnt), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0]  m_lctl [NL];
    logic [7:0]  m_mst  [NL];
    logic [15:0] m_adr  [NL];
    logic [15:0] m_cnt  [NL];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        data_sel = sel; byte_en = be; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        data_sel = sel;
        #1;
        v = rdata;
    endtask

    function automatic logic [15:0] exp_word(input int rs, input int ln);
        case (rs)
            0: return {rx_modem[ln*6 +: 6], 2'b00, 2'b00, silo_count[ln*CW +: CW]};
            1: return {m_mst[ln], m_lctl[ln]};
            2: return m_adr[ln];
            default: return m_cnt[ln];
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240607));
        for (int i = 0; i < NL; i++) begin
            silo_count[i*CW +: CW] = CW'(i*4 + 1);
            rx_modem[i*6 +: 6]     = 6'((i*7 + 5) % 64);
            m_lctl[i] = '0; m_mst[i] = '0; m_adr[i] = '0; m_cnt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b0, v);
        check("R1 csr", v, 16'h0000);
        check("R1 lctl", line_ctrl, '0);
        check("R1 modem", modem_out, '0);
        check("R1 strobes", {silo_push, silo_flush}, '0);

        // R2 enables and selector readback
        wr(1'b0, 2'b11, 16'h404A);
        rd(1'b0, v);
        check("R2 csr fields", v, 16'h404A);
        wr(1'b0, 2'b11, 16'hC7CA);
        rd(1'b0, v);
        check("R2 read-only line/ri", v & 16'h07FF, 16'h004A);

        // R4 receive request
        rx_ready = 1'b1;
        rd(1'b0, v);
        check("R2 ri follows input", v[7], 1'b1);
        check("R4 rx_irq set", rx_irq, 1'b1);
        wr(1'b0, 2'b01, 16'h000A);
        check("R4 rx_irq masked", rx_irq, 1'b0);
        rx_ready = 1'b0;

        // R3 transmit event
        @(negedge clk);
        tx_event = 1'b1; tx_line = 3'd5; tx_nxm = 1'b1;
        @(negedge clk);
        tx_event = 1'b0; tx_nxm = 1'b0;
        rd(1'b0, v);
        check("R3 event sets flags", v & 16'hE700, 16'hE500);
        check("R4 tx_irq", tx_irq, 1'b1);
        wr(1'b0, 2'b10, 16'h4000);
        rd(1'b0, v);
        check("R3 host clear", v & 16'hE700, 16'h4500);
        check("R4 tx_irq cleared", tx_irq, 1'b0);
        @(negedge clk);
        tx_event = 1'b1; tx_line = 3'd2;
        data_sel = 1'b0; byte_en = 2'b10; wdata = 16'h4000; wr_en = 1'b1;
        @(negedge clk);
        tx_event = 1'b0; wr_en = 1'b0;
        rd(1'b0, v);
        check("R3 event wins over clear", v & 16'h8700, 16'h8200);
        wr(1'b0, 2'b10, 16'h0000);

        // R6 character push on line 3
        wr(1'b0, 2'b01, 16'h0003);
        wr(1'b1, 2'b01, 16'h005A);
        check("R6 push one-hot", silo_push, 8'b0000_1000);
        check("R6 push data", silo_data, 8'h5A);
        @(negedge clk);
        check("R6 push single cycle", silo_push, 8'h00);
        wr(1'b1, 2'b10, 16'hA500);
        check("R6 high byte no push", silo_push, 8'h00);

        // R7 count and receive modem readback
        rd(1'b1, v);
        check("R7 char read", v, exp_word(0, 3));

        // R8 / R9 line control and modem status on line 6
        wr(1'b0, 2'b01, 16'h000E);
        wr(1'b1, 2'b11, 16'hFFFF);
        m_lctl[6] = 8'h2F; m_mst[6] = 8'hBF;
        check("R8 flush strobe", silo_flush, 8'b0100_0000);
        check("R8 lctl out", line_ctrl[36 +: 6], 6'h2F);
        check("R9 modem out", modem_out[30 +: 5], 5'h1F);
        rd(1'b1, v);
        check("R8 R9 readback", v, 16'hBF2F);
        @(negedge clk);
        check("R8 flush single cycle", silo_flush, 8'h00);

        // R10 R12 transfer address byte lanes on line 1
        wr(1'b0, 2'b01, 16'h0011);
        wr(1'b1, 2'b01, 16'h1234);
        wr(1'b1, 2'b10, 16'hAB00);
        m_adr[1] = 16'hAB34;
        rd(1'b1, v);
        check("R12 byte lanes", v, 16'hAB34);
        check("R10 dma addr out", dma_addr[16 +: 16], 16'hAB34);

        // R11 master clear
        wr(1'b0, 2'b11, 16'h4060);
        rd(1'b0, v);
        check("R11 clear bit visible", v & 16'hF8FF, 16'h4060);
        @(negedge clk);
        rd(1'b0, v);
        check("R11 clear done", v & 16'hF8FF, 16'h0000);
        check("R11 lctl cleared", line_ctrl, '0);
        check("R11 modem cleared", modem_out, '0);
        check("R11 dma kept", dma_addr[16 +: 16], 16'hAB34);
        for (int i = 0; i < NL; i++) begin m_lctl[i] = '0; m_mst[i] = '0; end

        // R5 R10 R12 seeded random
        for (int it = 0; it < 300; it++) begin
            int ln, rs;
            logic [1:0]  be;
            logic [15:0] d;
            ln = int'($urandom % NL);
            rs = int'($urandom % 4);
            be = 2'($urandom % 3 + 1);
            d  = 16'($urandom);
            wr(1'b0, 2'b01, 16'(rs * 8 + ln));
            wr(1'b1, be, d);
            case (rs)
                0: begin
                    check("R6 rand push", silo_push, be[0] ? NL'(1) << ln : '0);
                    if (be[0]) check("R6 rand data", silo_data, d[7:0]);
                end
                1: begin
                    if (be[0]) m_lctl[ln] = d[7:0] & 8'h2F;
                    if (be[1]) m_mst[ln]  = d[15:8] & 8'hBF;
                    check("R8 rand flush", silo_flush,
                          (be[0] && d[4]) ? NL'(1) << ln : '0);
                    check("R9 rand modem out", modem_out[ln*5 +: 5], m_mst[ln][4:0]);
                end
                2: begin
                    if (be[0]) m_adr[ln][7:0]  = d[7:0];
                    if (be[1]) m_adr[ln][15:8] = d[15:8];
                    check("R10 rand addr out", dma_addr[ln*16 +: 16], m_adr[ln]);
                end
                default: begin
                    if (be[0]) m_cnt[ln][7:0]  = d[7:0];
                    if (be[1]) m_cnt[ln][15:8] = d[15:8];
                    check("R10 rand count out", dma_cnt[ln*16 +: 16], m_cnt[ln]);
                end
            endcase
            rd(1'b1, v);
            check("R5 rand readback", v, exp_word(rs, ln));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule